// File: doc/BRIEF.md
# Watch Timer with Interval Interrupt

A free-running counter advances once per sub-clock tick (a 32 kHz enable that is synchronous to the bus clock). It raises a periodic interval flag. One 8-bit control register selects which power-of-two counter stage sets the flag. The same register holds the flag and its interrupt enable, and it has a write-zero strobe that clears the counter. A read-only bit reports when the sub-clock has run long enough to count as stable. One more bit chooses the clock source of an external watchdog and is driven straight to a pin.

Software uses the block through a single-register synchronous bus: a select, a write enable, write data and always-valid read data. The interrupt line is the AND of the flag and the enable. Software acknowledges the interval by writing 0 to the flag bit.

Top module: `watch_tmr`

## Requirements
- R1: After reset the register reads 8'h88: the watchdog select (bit 7) and the clear bit (bit 3) are 1, and every other bit is 0.
- R2: Read data is {wdog_sel[7], stable[6], int_en[5], int_flag[4], 1'b1[3], interval_code[2:0]}. Bit 3 always reads 1.
- R3: With interval code n (0 to 6), the flag sets on the clock edge of the 2^(TAP_BASE+1+n)-th sub-clock tick after the counter was cleared, and it sets again every 2^(TAP_BASE+1+n) ticks after that. With the default TAP_BASE=9 this gives 2^10 to 2^16 ticks (31.25 ms to 2 s at 32 kHz).
- R4: A write that carries code 3'b111 leaves the stored interval code unchanged. The other bits of that write still take effect.
- R5: A write with bit 3 = 0 sets the whole counter to zero. A sub-clock tick in the same cycle is discarded. A write with bit 3 = 1 leaves the counter alone.
- R6: A write with bit 4 = 0 clears the flag, and a write with bit 4 = 1 leaves it unchanged. If a set event coincides with a clearing write, the flag ends up set.
- R7: irq_o is 1 exactly when both int_flag and int_en are 1.
- R8: The stable bit reads 0 until 2^STABLE_LOG sub-clock ticks have passed since reset, then stays 1. Writes do not affect it.
- R9: wdg_src_o follows bit 7. Bit 7 is writable, where 0 selects the watch clock and 1 the timebase clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sub_tick_i | input | 1 | One-cycle enable per sub-clock period |
| reg_sel_i | input | 1 | Register address decode |
| reg_we_i | input | 1 | Write enable |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Register read data |
| irq_o | output | 1 | Interval interrupt request |
| wdg_src_o | output | 1 | Watchdog clock-source select |

## Verification
The bench uses a small tap base, which gives intervals of 4 to 256 ticks. It sweeps every valid code. For each one it checks that the flag is still clear one tick before the period and set exactly on it. It then re-arms the flag without clearing the counter, which separates a tap taken from the wrong stage from a counter that failed to wrap. Directed patterns put a counter-clear or a flag-clear write in the same cycle as a tick, which tests the two orders of precedence. The bench also checks the prohibited code, masking with the enable bit, and writes to the read-only stable bit before and after its threshold.

// File: rtl/wt_pkg.sv
package wt_pkg;
  localparam int unsigned BIT_WDG = 7;
  localparam int unsigned BIT_STB = 6;
  localparam int unsigned BIT_IE  = 5;
  localparam int unsigned BIT_FLG = 4;
  localparam int unsigned BIT_CLR = 3;
  localparam int unsigned CODE_W  = 3;
  localparam int unsigned NUM_SEL = (1 << CODE_W) - 1;
  localparam logic [CODE_W-1:0] CODE_BAD = '1;

  typedef struct packed {
    logic              wdg;
    logic              ie;
    logic              flg;
    logic [CODE_W-1:0] code;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{wdg: 1'b1, ie: 1'b0, flg: 1'b0, code: '0};
endpackage

// File: rtl/wt_counter.sv
module wt_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (tick_i) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/wt_tap.sv
module wt_tap
  import wt_pkg::*;
#(
  parameter int unsigned TAP_BASE = 9,
  localparam int unsigned CNT_W   = TAP_BASE + NUM_SEL
) (
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              tick_i,
  input  logic              clr_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              evt_o
);
  logic [(1<<CODE_W)-1:0] wrap;

  // tapped bit falls on the tick that sees all lower bits and the tap at one
  for (genvar g = 0; g < (1 << CODE_W); g++) begin : g_tap
    if (g < NUM_SEL) begin : g_on
      assign wrap[g] = &cnt_i[TAP_BASE+g:0];
    end else begin : g_off
      assign wrap[g] = 1'b0;
    end
  end

  assign evt_o = tick_i & ~clr_i & wrap[code_i];
endmodule

// File: rtl/wt_stable.sv
module wt_stable #(
  parameter int unsigned STABLE_LOG = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic done_o
);
  logic [STABLE_LOG-1:0] wait_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q <= '0;
      done_o <= 1'b0;
    end else if (tick_i && !done_o) begin
      wait_q <= wait_q + 1'b1;
      if (&wait_q) done_o <= 1'b1;
    end
  end
endmodule

// File: rtl/wt_ctrl_reg.sv
module wt_ctrl_reg
  import wt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  input  logic       evt_i,
  output ctrl_t      ctrl_o
);
  logic unused_wbits;
  assign unused_wbits = wdata_i[BIT_STB] ^ wdata_i[BIT_CLR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= CTRL_RST;
    end else begin
      if (wr_i) begin
        ctrl_o.wdg <= wdata_i[BIT_WDG];
        ctrl_o.ie  <= wdata_i[BIT_IE];
        if (wdata_i[CODE_W-1:0] != CODE_BAD) ctrl_o.code <= wdata_i[CODE_W-1:0];
      end
      // set beats a clearing write
      if (evt_i)                         ctrl_o.flg <= 1'b1;
      else if (wr_i && !wdata_i[BIT_FLG]) ctrl_o.flg <= 1'b0;
    end
  end
endmodule

// File: rtl/watch_tmr.sv
module watch_tmr
  import wt_pkg::*;
#(
  parameter int unsigned TAP_BASE   = 9,
  parameter int unsigned STABLE_LOG = 15,
  localparam int unsigned CNT_W     = TAP_BASE + NUM_SEL
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sub_tick_i,
  input  logic       reg_sel_i,
  input  logic       reg_we_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       irq_o,
  output logic       wdg_src_o
);
  logic             wr, clr, evt, stable;
  logic [CNT_W-1:0] cnt;
  ctrl_t            ctrl;

  assign wr  = reg_sel_i & reg_we_i;
  assign clr = wr & ~reg_wdata_i[BIT_CLR];

  wt_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk_i, .rst_ni, .tick_i(sub_tick_i), .clr_i(clr), .cnt_o(cnt)
  );

  wt_tap #(.TAP_BASE(TAP_BASE)) i_tap (
    .cnt_i(cnt), .tick_i(sub_tick_i), .clr_i(clr), .code_i(ctrl.code), .evt_o(evt)
  );

  wt_stable #(.STABLE_LOG(STABLE_LOG)) i_stb (
    .clk_i, .rst_ni, .tick_i(sub_tick_i), .done_o(stable)
  );

  wt_ctrl_reg i_reg (
    .clk_i, .rst_ni, .wr_i(wr), .wdata_i(reg_wdata_i), .evt_i(evt), .ctrl_o(ctrl)
  );

  assign reg_rdata_o = {ctrl.wdg, stable, ctrl.ie, ctrl.flg, 1'b1, ctrl.code};
  assign irq_o       = ctrl.flg & ctrl.ie;
  assign wdg_src_o   = ctrl.wdg;
endmodule

// File: rtl/watch_tmr_chk.sv
module watch_tmr_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sub_tick_i,
  input logic       reg_sel_i,
  input logic       reg_we_i,
  input logic [7:0] reg_wdata_i,
  input logic [7:0] reg_rdata_o,
  input logic       irq_o,
  input logic       wdg_src_o
);
  p_clr_reads_one_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[3]);

  p_irq_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (reg_rdata_o[5] & reg_rdata_o[4]));

  p_wdg_pin_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdg_src_o == reg_rdata_o[7]);

  p_no_bad_code_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[2:0] != 3'b111);

  p_bad_code_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_sel_i && reg_we_i && reg_wdata_i[2:0] == 3'b111) |=> $stable(reg_rdata_o[2:0]));

  p_stable_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[6] |=> reg_rdata_o[6]);

  p_flag_on_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reg_rdata_o[4]) |-> $past(sub_tick_i));

  p_flag_write_one_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_sel_i && reg_we_i && reg_wdata_i[4] && reg_rdata_o[4]) |=> reg_rdata_o[4]);
endmodule

bind watch_tmr watch_tmr_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sub_tick_i(sub_tick_i),
  .reg_sel_i(reg_sel_i), .reg_we_i(reg_we_i), .reg_wdata_i(reg_wdata_i),
  .reg_rdata_o(reg_rdata_o), .irq_o(irq_o), .wdg_src_o(wdg_src_o)
);

// File: tb/test_watch_tmr.sv
module test_watch_tmr;
  localparam int TAP_BASE   = 1;
  localparam int STABLE_LOG = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       sel = 1'b0;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq, wdg;
  int         checks = 0;
  int         errors = 0;

  always #10 clk = ~clk;

  watch_tmr #(.TAP_BASE(TAP_BASE), .STABLE_LOG(STABLE_LOG)) i_watch_tmr (
    .clk_i(clk), .rst_ni(rst_n), .sub_tick_i(tick), .reg_sel_i(sel),
    .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_o(irq), .wdg_src_o(wdg)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d, input logic t);
    sel = 1'b1; we = 1'b1; wdata = d; tick = t;
    @(negedge clk);
    sel = 1'b0; we = 1'b0; tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
    end
    tick = 1'b0;
  endtask

  function automatic int period(input int code);
    return 1 << (TAP_BASE + 1 + code);
  endfunction

  initial begin
    repeat (100000) @(negedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset value", rdata, 8'h88);
    chk("R1 irq low", irq, 0);
    chk("R9 wdg reset", wdg, 1);

    // R8: stable threshold, writes ignored
    ticks((1 << STABLE_LOG) - 1);
    wr(8'b1100_1000, 1'b0);
    chk("R8 not yet stable", rdata[6], 0);
    ticks(1);
    chk("R8 stable", rdata[6], 1);
    wr(8'b1000_1000, 1'b0);
    chk("R8 stable ignores write", rdata[6], 1);

    // R3 sweep, ie on, counter cleared
    for (int c = 0; c < 7; c++) begin
      wr({5'b1010_0, 3'(c)}, 1'b0);
      chk("R2 code readback", rdata[2:0], c);
      chk("R2 clear bit reads one", rdata[3], 1);
      chk("R6 flag cleared", rdata[4], 0);
      ticks(period(c) - 1);
      chk("R3 early", rdata[4], 0);
      chk("R7 irq early", irq, 0);
      ticks(1);
      chk("R3 on period", rdata[4], 1);
      chk("R7 irq set", irq, 1);
      wr({5'b1010_1, 3'(c)}, 1'b0);
      ticks(period(c) - 1);
      chk("R3 second early", rdata[4], 0);
      ticks(1);
      chk("R3 second period", rdata[4], 1);
    end

    // R4 prohibited code held
    wr(8'b1010_0011, 1'b0);
    wr(8'b1010_1111, 1'b0);
    chk("R4 code held", rdata[2:0], 3);
    ticks(period(3) - 1);
    chk("R4 early", rdata[4], 0);
    ticks(1);
    chk("R4 period of held code", rdata[4], 1);

    // R5 clear with simultaneous tick
    wr(8'b1010_0000, 1'b0);
    ticks(2);
    wr(8'b1010_0000, 1'b1);
    ticks(3);
    chk("R5 tick lost on clear", rdata[4], 0);
    ticks(1);
    chk("R5 period after clear", rdata[4], 1);

    // R6 write one keeps flag, set wins over clear
    wr(8'b1011_1000, 1'b0);
    chk("R6 write one keeps set flag", rdata[4], 1);
    wr(8'b1010_0000, 1'b0);
    wr(8'b1011_1000, 1'b0);
    chk("R6 write one keeps clear flag", rdata[4], 0);
    ticks(3);
    wr(8'b1010_1000, 1'b1);
    chk("R6 set wins", rdata[4], 1);

    // R7 masking
    wr(8'b1000_0000, 1'b0);
    ticks(4);
    chk("R7 flag with ie off", rdata[4], 1);
    chk("R7 irq masked", irq, 0);
    wr(8'b1011_1000, 1'b0);
    chk("R7 irq unmasked", irq, 1);

    // R9 watchdog select
    wr(8'b0000_1000, 1'b0);
    chk("R9 wdg zero", wdg, 0);
    chk("R9 readback", rdata, 8'h48);
    wr(8'b1000_1000, 1'b0);
    chk("R9 wdg one", wdg, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule